// File: doc/BRIEF.md
# Memory and I/O Bus Cycle Controller

This block takes one request at a time from a simple processor-side port and runs it as a bus cycle on one of two targets: a main-memory port or an I/O register port. A build-time parameter picks how I/O is addressed. In window mode, a reserved address range is steered to the I/O port and every other address goes to memory. In port mode, I/O uses its own 16-bit port-number space. A side flag on the request then picks I/O or memory, whatever the address is.

I/O cycles are stretched: the target select stays asserted for a longer, parameter-set number of cycles than a memory cycle. The requester raises a valid and holds it. The controller latches the request, runs the cycle, and returns a one-cycle ready pulse. Read data from the selected target comes back during that pulse. Only one transaction is in flight at any time.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, both target selects and the ready output are low.
- R2: In window mode (DIRECT_MODE=0), an address with (addr & IO_MASK) == (IO_BASE & IO_MASK) goes to the I/O port. The port number is the address's low 16 bits.
- R3: In window mode, every other address goes to the memory port with the full 32-bit address, and the I/O flag on the request has no effect on routing.
- R4: In port mode (DIRECT_MODE=1), a request with the I/O flag set goes to the I/O port with port number addr[15:0], whatever the address.
- R5: In port mode, a request with the I/O flag clear goes to memory, even when its address lies inside the I/O window.
- R6: A memory cycle keeps mem_sel high for exactly MEM_WAIT consecutive cycles, and ready is high in the last of them.
- R7: An I/O cycle keeps io_sel high for exactly IO_WAIT consecutive cycles, and ready is high in the last of them.
- R8: Ready is a single-cycle pulse. During it, the read data equals the selected target's read data. Outside it, the read data is zero.
- R9: At most one target select is high at a time. The write flag and write data go only to the selected target, unchanged.
- R10: A request is latched when it is accepted. Changes to the request inputs while a cycle is running do not change the target, address or port shown to the target.
- R11: When the controller is idle and valid is high at a clock edge, the chosen target's select is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | I/O flag, used in port mode only |
| req_addr | input | 32 | Memory address, or port number in the low 16 bits |
| req_wdata | input | 32 | Write data |
| req_rdy | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with ready |
| mem_sel | output | 1 | Memory cycle active |
| mem_write | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| io_sel | output | 1 | I/O cycle active |
| io_write | output | 1 | I/O write strobe |
| io_port | output | 16 | I/O port number |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data |

## Verification
If the latched target bit is wrong, it shows on the next cycle as the wrong select rising. It also shows as a cycle length of MEM_WAIT where IO_WAIT was due, or the reverse. A corrupted wait counter shows as a select held one cycle too long or too short, or as ready arriving at the wrong position in the select window. A lost latch shows as soon as the request inputs change during a cycle, because the target address then follows them. The sweep covers addresses on both sides of the window edges, both flag values and both directions, in both addressing modes at once.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    localparam int ADDR_W = 32;
    localparam int PORT_W = 16;
    localparam int DATA_W = 32;

    typedef enum logic {
        TGT_MEM = 1'b0,
        TGT_IO  = 1'b1
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input logic [ADDR_W-1:0] mask);
        return (addr & mask) == (base & mask);
    endfunction
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
#(
    parameter bit              DIRECT_MODE = 1'b0,
    parameter logic [ADDR_W-1:0] IO_BASE   = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] IO_MASK   = 32'hFFFF_0000
) (
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output xact_t             xact
);
    logic io_hit;

    generate
        if (DIRECT_MODE) begin : g_port_space
            // separate space: only the side flag selects I/O
            assign io_hit = req_io;
        end else begin : g_window
            // shared space: a reserved window selects I/O, flag ignored
            logic unused_req_io;
            assign unused_req_io = req_io;
            assign io_hit = in_window(req_addr, IO_BASE, IO_MASK);
        end
    endgenerate

    always_comb begin
        xact.tgt   = io_hit ? TGT_IO : TGT_MEM;
        xact.write = req_write;
        xact.addr  = req_addr;
        xact.wdata = req_wdata;
    end
endmodule

// File: rtl/bcc_timer.sv
module bcc_timer
    import bcc_pkg::*;
#(
    parameter int MEM_WAIT = 2,
    parameter int IO_WAIT  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  tgt_e tgt,
    output logic busy,
    output logic last
);
    localparam int MAX_WAIT = (IO_WAIT > MEM_WAIT) ? IO_WAIT : MEM_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] MEM_LOAD = CNT_W'(MEM_WAIT - 1);
    localparam logic [CNT_W-1:0] IO_LOAD  = CNT_W'(IO_WAIT - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= (tgt == TGT_IO) ? IO_LOAD : MEM_LOAD;
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    assign last = busy && (remain == '0);

    // a running cycle never outlasts the longest wait
    p_remain_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remain <= IO_LOAD || remain <= MEM_LOAD));
endmodule

// File: rtl/bcc_rsp.sv
module bcc_rsp
    import bcc_pkg::*;
(
    input  logic              last,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              rdy,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdy   = last;
        rdata = '0;
        if (last) begin
            rdata = (tgt == TGT_IO) ? io_rdata : mem_rdata;
        end
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter bit                DIRECT_MODE = 1'b0,
    parameter int                MEM_WAIT    = 2,
    parameter int                IO_WAIT     = 5,
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] IO_MASK     = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_rdy,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_sel,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              io_sel,
    output logic              io_write,
    output logic [PORT_W-1:0] io_port,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata
);
    localparam int CHK_W = $clog2(((IO_WAIT > MEM_WAIT) ? IO_WAIT : MEM_WAIT) + 1);

    xact_t dec_x;
    xact_t cur_x;
    logic  busy;
    logic  last;
    logic  start;

    bcc_decode #(
        .DIRECT_MODE (DIRECT_MODE),
        .IO_BASE     (IO_BASE),
        .IO_MASK     (IO_MASK)
    ) u_decode (
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .xact      (dec_x)
    );

    assign start = req_valid && !busy;

    bcc_timer #(
        .MEM_WAIT (MEM_WAIT),
        .IO_WAIT  (IO_WAIT)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tgt   (dec_x.tgt),
        .busy  (busy),
        .last  (last)
    );

    // request latch: inputs are sampled only on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_x <= '0;
        end else if (start) begin
            cur_x <= dec_x;
        end
    end

    always_comb begin
        mem_sel   = busy && (cur_x.tgt == TGT_MEM);
        io_sel    = busy && (cur_x.tgt == TGT_IO);
        mem_write = mem_sel && cur_x.write;
        io_write  = io_sel && cur_x.write;
        mem_addr  = mem_sel ? cur_x.addr : '0;
        mem_wdata = mem_sel ? cur_x.wdata : '0;
        io_port   = io_sel ? cur_x.addr[PORT_W-1:0] : '0;
        io_wdata  = io_sel ? cur_x.wdata : '0;
    end

    logic unused_addr_hi;
    assign unused_addr_hi = ^cur_x.addr[ADDR_W-1:PORT_W];

    bcc_rsp u_rsp (
        .last      (last),
        .tgt       (cur_x.tgt),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .rdy       (req_rdy),
        .rdata     (req_rdata)
    );

    // independent length counter for the select window
    logic [CHK_W-1:0] sel_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_len <= '0;
        end else if ((mem_sel || io_sel) && !req_rdy) begin
            sel_len <= sel_len + 1'b1;
        end else begin
            sel_len <= '0;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!mem_sel && !io_sel && !req_rdy));

    p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_sel, io_sel}));

    p_rdy_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        req_rdy |=> !req_rdy);

    p_rdy_inside_r8: assert property (@(posedge clk) disable iff (rst)
        req_rdy |-> (mem_sel || io_sel));

    p_accept_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_sel && !io_sel) |=> (mem_sel || io_sel));

    p_hold_mem_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && !req_rdy) |=> (mem_sel && $stable(mem_addr)));

    p_hold_io_r10: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !req_rdy) |=> (io_sel && $stable(io_port)));

    p_mem_len_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && req_rdy) |-> (sel_len == CHK_W'(MEM_WAIT - 1)));

    p_io_len_r7: assert property (@(posedge clk) disable iff (rst)
        (io_sel && req_rdy) |-> (sel_len == CHK_W'(IO_WAIT - 1)));

    generate
        if (DIRECT_MODE) begin : g_chk_port
            p_flag_io_r4: assert property (@(posedge clk) disable iff (rst)
                $rose(io_sel) |-> $past(req_io));
            p_flag_mem_r5: assert property (@(posedge clk) disable iff (rst)
                $rose(mem_sel) |-> !$past(req_io));
        end else begin : g_chk_window
            p_window_io_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(io_sel) |-> in_window($past(req_addr), IO_BASE, IO_MASK));
            p_window_mem_r3: assert property (@(posedge clk) disable iff (rst)
                $rose(mem_sel) |-> !in_window($past(req_addr), IO_BASE, IO_MASK));
        end
    endgenerate
endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          MEM_WAIT   = 2;
    localparam int          IO_WAIT    = 5;
    localparam logic [31:0] IO_BASE    = 32'hFFFF_0000;
    localparam logic [31:0] IO_MASK    = 32'hFFFF_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_write = 1'b0;
    logic        req_io    = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;

    // index 0: window mode, index 1: port mode
    logic        vld       [2];
    logic        rdy       [2];
    logic [31:0] rdata     [2];
    logic        mem_sel   [2];
    logic        mem_write [2];
    logic [31:0] mem_addr  [2];
    logic [31:0] mem_wdata [2];
    logic [31:0] mem_rdata [2];
    logic        io_sel    [2];
    logic        io_write  [2];
    logic [15:0] io_port   [2];
    logic [31:0] io_wdata  [2];
    logic [31:0] io_rdata  [2];

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            mem_rdata[i] = mem_addr[i] ^ 32'h5A5A_5A5A;
            io_rdata[i]  = {16'hC0DE, io_port[i]};
        end
    end

    bus_cycle_ctrl #(.DIRECT_MODE(1'b0), .MEM_WAIT(MEM_WAIT), .IO_WAIT(IO_WAIT),
                     .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_bus_cycle_ctrl (
        .clk(clk), .rst(rst), .req_valid(vld[0]), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdy(rdy[0]), .req_rdata(rdata[0]),
        .mem_sel(mem_sel[0]), .mem_write(mem_write[0]), .mem_addr(mem_addr[0]),
        .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata[0]),
        .io_sel(io_sel[0]), .io_write(io_write[0]), .io_port(io_port[0]),
        .io_wdata(io_wdata[0]), .io_rdata(io_rdata[0]));

    bus_cycle_ctrl #(.DIRECT_MODE(1'b1), .MEM_WAIT(MEM_WAIT), .IO_WAIT(IO_WAIT),
                     .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_bus_cycle_ctrl_port (
        .clk(clk), .rst(rst), .req_valid(vld[1]), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdy(rdy[1]), .req_rdata(rdata[1]),
        .mem_sel(mem_sel[1]), .mem_write(mem_write[1]), .mem_addr(mem_addr[1]),
        .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata[1]),
        .io_sel(io_sel[1]), .io_write(io_write[1]), .io_port(io_port[1]),
        .io_wdata(io_wdata[1]), .io_rdata(io_rdata[1]));

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_xact(input logic [31:0] addr, input bit io, input bit wr,
                            input logic [31:0] wd);
        bit          exp_io  [2];
        int          sel_cnt [2];
        int          rdy_at  [2];
        int          rdy_cnt [2];
        bit          wrong_t [2];
        bit          bad_out [2];
        bit          done    [2];
        logic [31:0] got_rd  [2];
        logic [31:0] exp_rd;
        int          exp_w;
        exp_io[0] = ((addr & IO_MASK) == (IO_BASE & IO_MASK));
        exp_io[1] = io;
        for (int i = 0; i < 2; i++) begin
            sel_cnt[i] = 0; rdy_at[i] = 0; rdy_cnt[i] = 0;
            wrong_t[i] = 0; bad_out[i] = 0; done[i] = 0; got_rd[i] = '0;
        end
        @(negedge clk);
        req_addr = addr; req_io = io; req_write = wr; req_wdata = wd;
        vld[0] = 1'b1; vld[1] = 1'b1;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                if (!done[i]) begin
                    if (exp_io[i] ? mem_sel[i] : io_sel[i]) wrong_t[i] = 1;
                    if (exp_io[i] ? io_sel[i] : mem_sel[i]) begin
                        sel_cnt[i]++;
                        if (exp_io[i]) begin
                            if (io_port[i] != addr[15:0] || io_write[i] != wr ||
                                io_wdata[i] != wd) bad_out[i] = 1;
                        end else begin
                            if (mem_addr[i] != addr || mem_write[i] != wr ||
                                mem_wdata[i] != wd) bad_out[i] = 1;
                        end
                    end
                    if (!rdy[i] && rdata[i] != '0) bad_out[i] = 1;
                    if (rdy[i]) begin
                        rdy_cnt[i]++;
                        rdy_at[i] = c;
                        got_rd[i] = rdata[i];
                        done[i] = 1;
                        vld[i] = 1'b0;
                    end
                end
            end
            // disturb the request inputs mid-cycle (R10)
            if (c == 1) begin
                req_addr = ~addr; req_io = ~io; req_write = ~wr; req_wdata = ~wd;
            end
            if (done[0] && done[1]) break;
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            exp_w  = exp_io[i] ? IO_WAIT : MEM_WAIT;
            exp_rd = exp_io[i] ? {16'hC0DE, addr[15:0]} : (addr ^ 32'h5A5A_5A5A);
            if (i == 0)
                check(!wrong_t[i], exp_io[i] ? "R2 window route" : "R3 window route",
                      32'(wrong_t[i]), 0);
            else
                check(!wrong_t[i], exp_io[i] ? "R4 port route" : "R5 port route",
                      32'(wrong_t[i]), 0);
            check(sel_cnt[i] == exp_w, exp_io[i] ? "R7 io length" : "R6 mem length",
                  sel_cnt[i], exp_w);
            check(rdy_at[i] == exp_w, "R6 R7 ready position", rdy_at[i], exp_w);
            check(rdy_cnt[i] == 1 && !rdy[i], "R8 ready pulse", rdy_cnt[i], 1);
            check(got_rd[i] == exp_rd, "R8 read data", got_rd[i], exp_rd);
            check(!bad_out[i], "R9 R10 target outputs", 32'(bad_out[i]), 0);
            check(!mem_sel[i] && !io_sel[i], "R11 back to idle",
                  {30'd0, mem_sel[i], io_sel[i]}, 0);
        end
    endtask

    task automatic accept_timing();
        @(negedge clk);
        req_addr = 32'h0000_1000; req_io = 1'b1; req_write = 1'b0;
        vld[0] = 1'b1; vld[1] = 1'b1;
        @(negedge clk);
        check(mem_sel[0], "R11 accept window", 32'(mem_sel[0]), 1);
        check(io_sel[1], "R11 accept port", 32'(io_sel[1]), 1);
        for (int c = 0; c < 10; c++) begin
            if (rdy[0]) vld[0] = 1'b0;
            if (rdy[1]) vld[1] = 1'b0;
            @(negedge clk);
        end
        vld[0] = 1'b0; vld[1] = 1'b0;
    endtask

    logic [31:0] addr_list [6];

    initial begin
        vld[0] = 1'b0; vld[1] = 1'b0;
        addr_list[0] = 32'h0000_0000;
        addr_list[1] = 32'hFFFE_FFFF;
        addr_list[2] = 32'hFFFF_0000;
        addr_list[3] = 32'hFFFF_FFFF;
        addr_list[4] = 32'h1234_5678;
        addr_list[5] = 32'hFFFF_8001;
        vld[0] = 1'b1; vld[1] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            check(!mem_sel[i] && !io_sel[i] && !rdy[i], "R1 reset idle",
                  {29'd0, mem_sel[i], io_sel[i], rdy[i]}, 0);
        vld[0] = 1'b0; vld[1] = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            check(!mem_sel[i] && !io_sel[i] && !rdy[i], "R1 after reset",
                  {29'd0, mem_sel[i], io_sel[i], rdy[i]}, 0);
        accept_timing();
        for (int a = 0; a < 6; a++)
            for (int f = 0; f < 2; f++)
                for (int w = 0; w < 2; w++)
                    run_xact(addr_list[a], f[0], w[0], addr_list[a] + 32'h0101_0101 * a);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule